// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register side of a twelve-pin general-purpose I/O expander. A transaction port carries bytes: a start strobe loads a register address from the byte lane, then each write or read strobe moves one data byte and steps the address by one. A single transaction can therefore touch a whole pin group. Each pin group is 24 bits wide and spans three neighbouring byte addresses, lowest byte first. The serial framing that would produce these strobes sits outside the block.

The core holds the pin direction, the pull selection, the output latch and a global enable. It also returns an identity byte and the synchronized pin inputs. The output latch changes only through two strobe addresses, one that raises bits and one that lowers them. Output drivers and input reporting stay off until software sets the enable bit.

A three-state machine tracks the transaction. ST_IDLE means no transaction is open. ST_OPEN means an address is loaded and bytes are accepted. ST_REPLY means a read byte is on the output.
- ST_IDLE goes to ST_OPEN on a start strobe.
- From ST_OPEN or ST_REPLY, a start goes to ST_OPEN and reloads the address. A stop goes to ST_IDLE. A read goes to ST_REPLY. A write, or no strobe, goes to ST_OPEN.
- Priority is start, then stop, then read, then write.

Top module: `gpx_core`

## Requirements
- R1: Address 0x00 reads 0x7B, and a write to it changes nothing.
- R2: Inside an open transaction, every accepted data byte (read or write) advances the address by one. The address wraps from 0xFF to 0x00.
- R3: A pin group occupies base, base+1 and base+2, holding pin bits 0-7, 8-15 and 16-23. The bases are: input state 0x10, direction 0x60, pull select 0x68, set strobe 0x6C, clear strobe 0x70.
- R4: A 1 written in the set group raises that pin's output latch. A 0 leaves the latch unchanged. `pin_out` shows the latch after the accepting edge.
- R5: A 1 written in the clear group lowers that pin's latch. A 0 leaves the latch unchanged.
- R6: A direction bit of 1 makes the pin an output. While the enable bit is set, `pin_oe` equals the direction bits.
- R7: A pull bit of 1 selects pull-up and 0 selects pull-down. `pin_pu` equals the pull bits.
- R8: Bit 0 of the system control byte at 0x40 is the enable, and it reads back. While it is 0, `pin_oe` is all zero and the input group reads 0x00.
- R9: Only pins 0-11 exist. Unimplemented group bits read as 0, whatever was written to them.
- R10: A pin input passes through two flops before it appears in the input group. A read accepted at the second edge after an input change still returns the old value.
- R11: After reset, direction, pull, latch and enable are zero. Unmapped addresses and the two strobe groups read 0x00.
- R12: Write and read strobes outside an open transaction, or in the same cycle as a start or stop, are ignored.
- R13: A read accepted at an edge puts its byte on `byte_out` with `byte_out_vld` high for the following cycle. `byte_out_vld` is low in any cycle that follows no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | Open or restart a transaction; `byte_in` holds the address |
| txn_stop | input | 1 | Close the transaction |
| byte_wr | input | 1 | Write `byte_in` at the current address |
| byte_rd | input | 1 | Read the current address |
| byte_in | input | 8 | Address or write data |
| byte_out | output | 8 | Read data |
| byte_out_vld | output | 1 | `byte_out` holds the byte of the read accepted at the last edge |
| pin_in | input | 12 | Raw pin levels |
| pin_out | output | 12 | Output latch |
| pin_oe | output | 12 | Output enables |
| pin_pu | output | 12 | Pull select, 1 = up |

## Verification
- Register writes show on `pin_out`, `pin_oe` and `pin_pu` one edge after the write strobe is accepted.
- A read byte shows on `byte_out` one edge after the read strobe.
- An input change needs two edges to reach the state group, so a read accepted at the second edge returns the old value and a read at the third returns the new one.
- The bench drives strobes on the falling edge and samples on the next falling edge, exactly one accepting edge later. The input-path test reads at the second and third edges to pin the synchronizer depth.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int ADDR_W      = 8;
    localparam int BYTE_W      = 8;
    localparam int GROUP_BYTES = 3;
    localparam int LANE_W      = 2;

    localparam logic [ADDR_W-1:0] A_IDENT  = 8'h00;
    localparam logic [ADDR_W-1:0] A_INPUT  = 8'h10;
    localparam logic [ADDR_W-1:0] A_SYSCTL = 8'h40;
    localparam logic [ADDR_W-1:0] A_DIR    = 8'h60;
    localparam logic [ADDR_W-1:0] A_PULL   = 8'h68;
    localparam logic [ADDR_W-1:0] A_SET    = 8'h6C;
    localparam logic [ADDR_W-1:0] A_CLR    = 8'h70;

    localparam logic [BYTE_W-1:0] IDENT_VALUE = 8'h7B;
    localparam logic [ADDR_W-1:0] GROUP_SPAN  = ADDR_W'(GROUP_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_REPLY = 2'd2
    } gpx_state_e;

    // True when addr falls inside the three-byte group starting at base
    function automatic logic in_group(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] d;
        d = addr - base;
        return (addr >= base) && (d < GROUP_SPAN);
    endfunction

    // Byte lane of addr inside the group starting at base
    function automatic logic [LANE_W-1:0] group_lane(input logic [ADDR_W-1:0] addr,
                                                     input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] d;
        d = addr - base;
        return d[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/gpx_in_sync.sv
module gpx_in_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpx_txn_fsm.sv
module gpx_txn_fsm
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_stop,
    input  logic              byte_wr,
    input  logic              byte_rd,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] cur_addr,
    output gpx_state_e        cur_state,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_out_vld
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

    gpx_state_e state_q, state_d;
    logic       accept, rd_take;

    always_comb begin
        accept  = (state_q != ST_IDLE) && !txn_start && !txn_stop;
        rd_take = accept && byte_rd;
        wr_stb  = accept && byte_wr && !byte_rd;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (txn_start) state_d = ST_OPEN;
            end
            ST_OPEN, ST_REPLY: begin
                if (txn_start)     state_d = ST_OPEN;
                else if (txn_stop) state_d = ST_IDLE;
                else if (byte_rd)  state_d = ST_REPLY;
                else               state_d = ST_OPEN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            byte_out <= '0;
        end else begin
            if (txn_start)             cur_addr <= byte_in[ADDR_W-1:0];
            else if (rd_take || wr_stb) cur_addr <= cur_addr + ADDR_STEP;
            if (rd_take)               byte_out <= rd_byte;
        end
    end

    assign cur_state    = state_q;
    assign byte_out_vld = (state_q == ST_REPLY);

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu,
    output logic              gpio_en
);

    localparam int PORT_W = GROUP_BYTES * BYTE_W;
    typedef logic [PORT_W-1:0] port_t;
    typedef logic [NPINS-1:0]  pins_t;

    pins_t dir_q, pull_q, lat_q;
    pins_t dir_d, pull_d, lat_d;
    logic  en_q, en_d;

    port_t w_spread, m_dir, m_pull, m_set, m_clr;

    // Lane mask for one group, zero when the write misses it
    function automatic port_t lane_mask(input logic stb,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base);
        port_t m;
        m = '0;
        if (stb && in_group(addr, base))
            m = port_t'({BYTE_W{1'b1}}) << {group_lane(addr, base), 3'b000};
        return m;
    endfunction

    always_comb begin
        m_dir    = lane_mask(wr_stb, wr_addr, A_DIR);
        m_pull   = lane_mask(wr_stb, wr_addr, A_PULL);
        m_set    = lane_mask(wr_stb, wr_addr, A_SET);
        m_clr    = lane_mask(wr_stb, wr_addr, A_CLR);
        w_spread = '0;
        for (int b = 0; b < GROUP_BYTES; b++)
            w_spread[b*BYTE_W +: BYTE_W] = wr_data;

        dir_d  = pins_t'((port_t'(dir_q)  & ~m_dir)  | (w_spread & m_dir));
        pull_d = pins_t'((port_t'(pull_q) & ~m_pull) | (w_spread & m_pull));
        lat_d  = pins_t'((port_t'(lat_q) | (w_spread & m_set)) & ~(w_spread & m_clr));
        en_d   = (wr_stb && wr_addr == A_SYSCTL) ? wr_data[0] : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            pull_q <= '0;
            lat_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            dir_q  <= dir_d;
            pull_q <= pull_d;
            lat_q  <= lat_d;
            en_q   <= en_d;
        end
    end

    // Read path: pick a group, then shift out the addressed lane
    port_t             sel_val, state_w;
    logic [LANE_W-1:0] sel_lane;
    logic              sel_hit;

    always_comb begin
        state_w  = en_q ? port_t'(pin_sync) : '0;
        sel_val  = '0;
        sel_lane = '0;
        sel_hit  = 1'b0;
        if (in_group(rd_addr, A_INPUT)) begin
            sel_val = state_w; sel_lane = group_lane(rd_addr, A_INPUT); sel_hit = 1'b1;
        end else if (in_group(rd_addr, A_DIR)) begin
            sel_val = port_t'(dir_q); sel_lane = group_lane(rd_addr, A_DIR); sel_hit = 1'b1;
        end else if (in_group(rd_addr, A_PULL)) begin
            sel_val = port_t'(pull_q); sel_lane = group_lane(rd_addr, A_PULL); sel_hit = 1'b1;
        end

        if (rd_addr == A_IDENT)       rd_byte = IDENT_VALUE;
        else if (rd_addr == A_SYSCTL) rd_byte = {{(BYTE_W-1){1'b0}}, en_q};
        else if (sel_hit)             rd_byte = BYTE_W'(sel_val >> {sel_lane, 3'b000});
        else                          rd_byte = '0;
    end

    assign pin_out = lat_q;
    assign pin_oe  = dir_q & {NPINS{en_q}};
    assign pin_pu  = pull_q;
    assign gpio_en = en_q;

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int NPINS       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_stop,
    input  logic              byte_wr,
    input  logic              byte_rd,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_out_vld,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu
);

    logic [ADDR_W-1:0] cur_addr;
    gpx_state_e        cur_state;
    logic              wr_stb;
    logic [BYTE_W-1:0] rd_byte;
    logic [NPINS-1:0]  pin_sync;
    logic              gpio_en;

    gpx_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpx_txn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start   (txn_start),
        .txn_stop    (txn_stop),
        .byte_wr     (byte_wr),
        .byte_rd     (byte_rd),
        .byte_in     (byte_in),
        .rd_byte     (rd_byte),
        .cur_addr    (cur_addr),
        .cur_state   (cur_state),
        .wr_stb      (wr_stb),
        .byte_out    (byte_out),
        .byte_out_vld(byte_out_vld)
    );

    gpx_regfile #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (cur_addr),
        .wr_data (byte_in),
        .rd_addr (cur_addr),
        .pin_sync(pin_sync),
        .rd_byte (rd_byte),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu),
        .gpio_en (gpio_en)
    );

endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk
    import gpx_pkg::*;
#(
    parameter int NPINS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_start,
    input logic              txn_stop,
    input logic              byte_wr,
    input logic              byte_rd,
    input logic [BYTE_W-1:0] byte_in,
    input logic [BYTE_W-1:0] byte_out,
    input logic              byte_out_vld,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_pu,
    input logic [ADDR_W-1:0] cur_addr,
    input gpx_state_e        cur_state
);

    localparam int L0 = (NPINS < BYTE_W) ? NPINS : BYTE_W;

    logic acc, rd_acc, wr_acc;
    assign acc    = (cur_state != ST_IDLE) && !txn_start && !txn_stop;
    assign rd_acc = acc && byte_rd;
    assign wr_acc = acc && byte_wr && !byte_rd;

    p_ident_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cur_addr == A_IDENT) |=> (byte_out == IDENT_VALUE));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc || wr_acc) |=> (cur_addr == $past(cur_addr) + 8'd1));

    p_set_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cur_addr == A_SET) |=>
        ((pin_out[L0-1:0] & $past(byte_in[L0-1:0])) == $past(byte_in[L0-1:0])));

    p_clr_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cur_addr == A_CLR) |=>
        ((pin_out[L0-1:0] & $past(byte_in[L0-1:0])) == '0));

    p_disable_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cur_addr == A_SYSCTL && !byte_in[0]) |=> (pin_oe == '0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));

    p_reply_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> byte_out_vld);

    p_reply_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !byte_out_vld);

endmodule

bind gpx_core gpx_core_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .txn_stop    (txn_stop),
    .byte_wr     (byte_wr),
    .byte_rd     (byte_rd),
    .byte_in     (byte_in),
    .byte_out    (byte_out),
    .byte_out_vld(byte_out_vld),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pin_pu      (pin_pu),
    .cur_addr    (cur_addr),
    .cur_state   (cur_state)
);

// File: tb/gpx_core_test.sv
module gpx_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_start = 1'b0, txn_stop = 1'b0, byte_wr = 1'b0, byte_rd = 1'b0;
    logic [7:0]    byte_in = '0;
    logic [7:0]    byte_out;
    logic          byte_out_vld;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_pu;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpx_core #(.NPINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .byte_wr(byte_wr), .byte_rd(byte_rd), .byte_in(byte_in),
        .byte_out(byte_out), .byte_out_vld(byte_out_vld), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every op starts and ends at a falling edge
    task automatic op_start(input logic [7:0] a);
        txn_start = 1'b1; byte_in = a;
        @(negedge clk); txn_start = 1'b0;
    endtask
    task automatic op_stop();
        txn_stop = 1'b1;
        @(negedge clk); txn_stop = 1'b0;
    endtask
    task automatic op_wr(input logic [7:0] d);
        byte_wr = 1'b1; byte_in = d;
        @(negedge clk); byte_wr = 1'b0;
    endtask
    task automatic op_rd(input string req, input logic [7:0] exp);
        byte_rd = 1'b1;
        @(negedge clk); byte_rd = 1'b0;
        check_eq(req, {31'd0, byte_out_vld}, 32'd1);
        check_eq(req, {24'd0, byte_out}, {24'd0, exp});
    endtask
    task automatic wr3(input logic [7:0] a, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2);
        op_start(a); op_wr(b0); op_wr(b1); op_wr(b2); op_stop();
    endtask
    task automatic wr1(input logic [7:0] a, input logic [7:0] b0);
        op_start(a); op_wr(b0); op_stop();
    endtask

    task automatic t_reset();
        check_eq("R11 pin_out", {20'd0, pin_out}, 0);
        check_eq("R11 pin_oe", {20'd0, pin_oe}, 0);
        check_eq("R11 pin_pu", {20'd0, pin_pu}, 0);
        check_eq("R13 vld idle", {31'd0, byte_out_vld}, 0);
        op_start(8'h60);
        op_rd("R11 dir b0", 8'h00); op_rd("R11 dir b1", 8'h00); op_rd("R11 dir b2", 8'h00);
        op_stop();
        op_start(8'h20); op_rd("R11 unmapped", 8'h00); op_stop();
        op_start(8'h6C); op_rd("R11 set reads 0", 8'h00); op_stop();
        op_start(8'h40); op_rd("R11 sysctl", 8'h00); op_stop();
    endtask

    task automatic t_identity();
        op_start(8'h00); op_rd("R1 ident", 8'h7B); op_stop();
        wr1(8'h00, 8'h55);
        op_start(8'h00); op_rd("R1 ident after write", 8'h7B); op_stop();
    endtask

    task automatic t_enable();
        wr3(8'h60, 8'hFF, 8'h0F, 8'hFF);
        check_eq("R8 oe off while disabled", {20'd0, pin_oe}, 0);
        op_start(8'h60);
        op_rd("R3 dir b0", 8'hFF); op_rd("R9 dir b1 upper nibble", 8'h0F);
        op_rd("R9 dir b2 zero", 8'h00);
        op_stop();
        wr1(8'h40, 8'h01);
        check_eq("R6 oe all outputs", {20'd0, pin_oe}, 32'hFFF);
        op_start(8'h40); op_rd("R8 sysctl readback", 8'h01); op_stop();
    endtask

    task automatic t_set_clear();
        op_start(8'h6C); op_wr(8'h05); op_wr(8'h0A); op_stop();
        check_eq("R4 set lsb first", {20'd0, pin_out}, 32'hA05);
        op_start(8'h6C); op_wr(8'h00); op_wr(8'h00); op_stop();
        check_eq("R4 zeros keep latch", {20'd0, pin_out}, 32'hA05);
        op_start(8'h70); op_wr(8'h01); op_wr(8'h08); op_stop();
        check_eq("R5 clear", {20'd0, pin_out}, 32'h204);
    endtask

    task automatic t_pull_dir();
        wr3(8'h68, 8'h3C, 8'h02, 8'hFF);
        check_eq("R7 pull select", {20'd0, pin_pu}, 32'h23C);
        op_start(8'h68);
        op_rd("R7 pull b0", 8'h3C); op_rd("R7 pull b1", 8'h02); op_rd("R9 pull b2", 8'h00);
        op_stop();
        op_start(8'h60); op_wr(8'h0F); op_wr(8'h00); op_stop();
        check_eq("R6 mixed dir", {20'd0, pin_oe}, 32'h00F);
    endtask

    task automatic t_inputs();
        pin_in = 12'hABC; txn_start = 1'b1; byte_in = 8'h10;
        @(negedge clk); txn_start = 1'b0;
        op_rd("R10 second edge still old", 8'h00);
        op_rd("R10 new value b1", 8'h0A);
        op_rd("R9 input b2", 8'h00);
        op_stop();
        op_start(8'h10); op_rd("R3 input b0", 8'hBC); op_stop();
        wr1(8'h40, 8'h00);
        check_eq("R8 oe off after disable", {20'd0, pin_oe}, 0);
        op_start(8'h10); op_rd("R8 input hidden", 8'h00); op_stop();
        wr1(8'h40, 8'h01);
        check_eq("R8 oe back", {20'd0, pin_oe}, 32'h00F);
    endtask

    task automatic t_idle_ignore();
        op_start(8'h6C); op_stop();
        byte_wr = 1'b1; byte_in = 8'hFF;
        @(negedge clk); byte_wr = 1'b0;
        check_eq("R12 idle write latch", {20'd0, pin_out}, 32'h204);
        byte_rd = 1'b1;
        @(negedge clk); byte_rd = 1'b0;
        check_eq("R12 idle read no vld", {31'd0, byte_out_vld}, 0);
        op_start(8'h6C);
        txn_stop = 1'b1; byte_wr = 1'b1; byte_in = 8'hFF;
        @(negedge clk); txn_stop = 1'b0; byte_wr = 1'b0;
        check_eq("R12 write with stop", {20'd0, pin_out}, 32'h204);
    endtask

    task automatic t_wrap_timing();
        op_start(8'hFF);
        check_eq("R13 vld low after start", {31'd0, byte_out_vld}, 0);
        op_rd("R2 addr FF", 8'h00);
        op_rd("R2 wrap to ident", 8'h7B);
        @(negedge clk);
        check_eq("R13 vld drops", {31'd0, byte_out_vld}, 0);
        op_stop();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_enable();
        t_set_clear();
        t_pull_dir();
        t_inputs();
        t_idle_ignore();
        t_wrap_timing();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule